// File: doc/BRIEF.md
# Base-Update Load/Store Address and Writeback Unit

This unit is the address-generation and writeback stage of a load/store pipeline for memory operations that also update their base register. Each accepted operation carries an access size, a load/store flag, a sign-extension flag, an immediate/indexed flag, a pre/post update flag, the base and target register numbers, the base value, the index value, the displacement field and the store data. The unit issues exactly one memory request for it. When the memory answers, the unit returns the loaded value and the new base value on two separate register write ports.

Two update modes are supported. In pre-update mode the access goes to base plus offset, and that same sum becomes the new base. In post-update mode the access goes to the unmodified base, and base plus offset is written back only after the access has finished. Operations that name register 0 as base, and loads whose base and target registers are the same, are refused. A refused operation raises a one-cycle illegal flag and causes no memory traffic and no writeback.

The operation input and the memory request are valid/ready streams. A producer must hold `op_*` stable while `op_valid` is high and `op_ready` is low. `op_ready` is low from acceptance until the cycle in which the writeback is presented. The request holds `mreq_*` stable until `mreq_ready` is seen. One response (`mresp_valid` for one cycle, carrying read data for a load or acting as the acknowledge for a store) is expected per request, and it is taken only after the request has been accepted.

Top module: `postinc_lsu`

## Requirements
- R1: In post-update mode (`op_post`=1) the request address `mreq_addr` equals the base value `op_base` unchanged.
- R2: In post-update mode the base write port carries `op_base` plus the sign-extended offset, to register `op_base_idx`.
- R3: In pre-update mode the request address is `op_base` plus the sign-extended offset, and the base write port carries that same address.
- R4: With `op_indexed`=1 the offset is `op_index` at full width. With `op_indexed`=0 and size code 0, 1 or 2, the offset is the 16-bit `op_disp` sign-extended.
- R5: With `op_indexed`=0 and size code 3 (8 bytes), the offset is `op_disp[13:0]` with two zero bits appended below, then sign-extended from bit 15. `op_disp[15:14]` are ignored.
- R6: Size codes are 0=1, 1=2, 2=4 and 3=8 bytes. A load with `op_signed`=0 returns the low 1, 2 or 4 bytes of `mresp_data` with all upper bits zero, and an 8-byte load returns all bits.
- R7: A load with `op_signed`=1 and size code 1 or 2 sign-extends the 16- or 32-bit value to full width. For size codes 0 and 3, `op_signed` has no effect.
- R8: For a store, `mreq_we`=1 and `mreq_size` equals the size code. `mreq_wdata` holds only the low 1, 2, 4 or 8 bytes of `op_sdata`, with all other bits zero.
- R9: When `op_base_idx`=0, or for a load when `op_base_idx`=`op_tgt_idx`, `illegal` pulses for one cycle after acceptance. In that case no request is issued, no write port is enabled, and `op_ready` stays high.
- R10: `mreq_valid` and `mreq_addr` hold until `mreq_ready` is seen. `op_ready` is low from acceptance until the writeback cycle.
- R11: One cycle after `mresp_valid` is seen, a load enables both write ports in the same cycle (`wb_rt_en` with the formatted data to `op_tgt_idx`), while a store enables only the base write port. In that cycle `op_ready` is high again.
- R12: After reset `op_ready`=1, and `mreq_valid`, `wb_rt_en`, `wb_ra_en` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation valid |
| op_ready | output | 1 | Unit idle and able to accept an operation |
| op_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| op_store | input | 1 | 1 = store, 0 = load |
| op_signed | input | 1 | Sign-extend loaded halfword/word |
| op_indexed | input | 1 | 1 = offset from index register, 0 = displacement |
| op_post | input | 1 | 1 = post-update, 0 = pre-update |
| op_base_idx | input | 5 | Base register number |
| op_tgt_idx | input | 5 | Load target / store source register number |
| op_base | input | XLEN | Base register value |
| op_index | input | XLEN | Index register value |
| op_disp | input | 16 | Displacement field |
| op_sdata | input | XLEN | Store data register value |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_addr | output | XLEN | Access address |
| mreq_we | output | 1 | 1 = write |
| mreq_size | output | 2 | Access size code |
| mreq_wdata | output | XLEN | Write data, right-aligned and masked |
| mresp_valid | input | 1 | Read data or store acknowledge |
| mresp_data | input | XLEN | Read data, right-aligned |
| wb_rt_en | output | 1 | Target register write enable |
| wb_rt_idx | output | 5 | Target register number |
| wb_rt_data | output | XLEN | Formatted load result |
| wb_ra_en | output | 1 | Base register write enable |
| wb_ra_idx | output | 5 | Base register number |
| wb_ra_data | output | XLEN | Updated base value |
| illegal | output | 1 | Refused-operation pulse |

## Verification
The embedded properties check on every cycle that a stalled request holds its address, that the unit is never ready while a request is outstanding, that a target write always pairs with a base write, that the idle state returns together with the writeback, and that a refused operation never shows a request or a write enable. Only the scenarios can show the arithmetic itself. This covers which address pre- and post-update pick, the scaled displacement for 8-byte accesses, the sign and zero fill of loaded data, and the masking of store data. Against these, the bench's scoreboard compares each request and each writeback with values it derives on its own.

// File: rtl/postinc_pkg.sv
package postinc_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_REQ = 2'd1, PH_WAIT = 2'd2} phase_e;
  localparam int DISP_W = 16;
  localparam int REG_IDX_W = 5;
endpackage

// File: rtl/pinc_addr.sv
module pinc_addr
  import postinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   index,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  input  logic              indexed,
  input  logic              post,
  output logic [XLEN-1:0]   ea,
  output logic [XLEN-1:0]   upd
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [DISP_W-1:0] field;
  logic [XLEN-1:0]   offset;
  logic [XLEN-1:0]   sum;

  // 8-byte immediate form: word-scaled displacement
  always_comb begin
    if (size == SZ_D) field = {disp[DISP_W-3:0], 2'b00};
    else              field = disp;
  end

  assign offset = indexed ? index : {{EXT_W{field[DISP_W-1]}}, field};
  assign sum    = base + offset;
  assign ea     = post ? base : sum;
  assign upd    = sum;
endmodule

// File: rtl/pinc_stfmt.sv
module pinc_stfmt
  import postinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] sdata,
  input  acc_size_e       size,
  output logic [XLEN-1:0] wdata
);
  localparam int LANES = XLEN / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int NEED = (i == 0) ? 0 : $clog2(i + 1);
    logic keep;
    assign keep = ({30'd0, size} >= 32'(NEED));
    assign wdata[8*i +: 8] = keep ? sdata[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/pinc_ldfmt.sv
module pinc_ldfmt
  import postinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  acc_size_e       size,
  input  logic            sgn,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] ext [2];

  // halfword (g=0) and word (g=1) extension paths
  for (genvar g = 0; g < 2; g++) begin : g_ext
    localparam int W = 16 << g;
    assign ext[g] = {{(XLEN-W){sgn & raw[W-1]}}, raw[W-1:0]};
  end

  always_comb begin
    unique case (size)
      SZ_B:    res = {{(XLEN-8){1'b0}}, raw[7:0]};
      SZ_H:    res = ext[0];
      SZ_W:    res = ext[1];
      default: res = raw;
    endcase
  end
endmodule

// File: rtl/postinc_lsu.sv
module postinc_lsu
  import postinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [1:0]           op_size,
  input  logic                 op_store,
  input  logic                 op_signed,
  input  logic                 op_indexed,
  input  logic                 op_post,
  input  logic [4:0]           op_base_idx,
  input  logic [4:0]           op_tgt_idx,
  input  logic [XLEN-1:0]      op_base,
  input  logic [XLEN-1:0]      op_index,
  input  logic [15:0]          op_disp,
  input  logic [XLEN-1:0]      op_sdata,
  output logic                 mreq_valid,
  input  logic                 mreq_ready,
  output logic [XLEN-1:0]      mreq_addr,
  output logic                 mreq_we,
  output logic [1:0]           mreq_size,
  output logic [XLEN-1:0]      mreq_wdata,
  input  logic                 mresp_valid,
  input  logic [XLEN-1:0]      mresp_data,
  output logic                 wb_rt_en,
  output logic [4:0]           wb_rt_idx,
  output logic [XLEN-1:0]      wb_rt_data,
  output logic                 wb_ra_en,
  output logic [4:0]           wb_ra_idx,
  output logic [XLEN-1:0]      wb_ra_data,
  output logic                 illegal
);
  phase_e                 phase_q;
  acc_size_e              in_size, sz_q;
  logic [XLEN-1:0]        ea_d, upd_d, wdata_d, ld_res;
  logic [XLEN-1:0]        addr_q, upd_q, wdata_q;
  logic                   we_q, sgn_q;
  logic [REG_IDX_W-1:0]   rt_q, ra_q;
  logic                   accept, refuse;

  assign in_size = acc_size_e'(op_size);

  pinc_addr #(.XLEN(XLEN)) u_addr (
    .base(op_base), .index(op_index), .disp(op_disp), .size(in_size),
    .indexed(op_indexed), .post(op_post), .ea(ea_d), .upd(upd_d)
  );

  pinc_stfmt #(.XLEN(XLEN)) u_st (
    .sdata(op_sdata), .size(in_size), .wdata(wdata_d)
  );

  pinc_ldfmt #(.XLEN(XLEN)) u_ld (
    .raw(mresp_data), .size(sz_q), .sgn(sgn_q), .res(ld_res)
  );

  assign op_ready = (phase_q == PH_IDLE);
  assign accept   = op_valid && op_ready;
  assign refuse   = (op_base_idx == '0) || (!op_store && (op_base_idx == op_tgt_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      sz_q       <= SZ_B;
      addr_q     <= '0;
      upd_q      <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      sgn_q      <= 1'b0;
      rt_q       <= '0;
      ra_q       <= '0;
      wb_rt_en   <= 1'b0;
      wb_ra_en   <= 1'b0;
      wb_rt_data <= '0;
      wb_ra_data <= '0;
      illegal    <= 1'b0;
    end else begin
      wb_rt_en <= 1'b0;
      wb_ra_en <= 1'b0;
      illegal  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            if (refuse) begin
              illegal <= 1'b1;
            end else begin
              phase_q <= PH_REQ;
              sz_q    <= in_size;
              addr_q  <= ea_d;
              upd_q   <= upd_d;
              wdata_q <= wdata_d;
              we_q    <= op_store;
              sgn_q   <= op_signed;
              rt_q    <= op_tgt_idx;
              ra_q    <= op_base_idx;
            end
          end
        end
        PH_REQ: begin
          if (mreq_ready) phase_q <= PH_WAIT;
        end
        PH_WAIT: begin
          if (mresp_valid) begin
            phase_q    <= PH_IDLE;
            wb_ra_en   <= 1'b1;
            wb_ra_data <= upd_q;
            wb_rt_en   <= !we_q;
            wb_rt_data <= ld_res;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign mreq_valid = (phase_q == PH_REQ);
  assign mreq_addr  = addr_q;
  assign mreq_we    = we_q;
  assign mreq_size  = sz_q;
  assign mreq_wdata = wdata_q;
  assign wb_rt_idx  = rt_q;
  assign wb_ra_idx  = ra_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> !op_ready); // R10
  AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_rt_en |-> wb_ra_en); // R11
  AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ra_en |-> op_ready && !mreq_valid); // R11
  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_ra_en && !wb_rt_en && !mreq_valid && op_ready); // R9
endmodule

// File: tb/postinc_lsu_test.sv
module postinc_lsu_test;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [1:0] op_size = '0;
  logic op_store = 1'b0, op_signed = 1'b0, op_indexed = 1'b0, op_post = 1'b0;
  logic [4:0] op_base_idx = '0, op_tgt_idx = '0;
  logic [XL-1:0] op_base = '0, op_index = '0, op_sdata = '0;
  logic [15:0] op_disp = '0;
  logic mreq_valid, mreq_ready = 1'b0, mreq_we;
  logic [XL-1:0] mreq_addr, mreq_wdata;
  logic [1:0] mreq_size;
  logic mresp_valid = 1'b0;
  logic [XL-1:0] mresp_data = '0;
  logic wb_rt_en, wb_ra_en, illegal;
  logic [4:0] wb_rt_idx, wb_ra_idx;
  logic [XL-1:0] wb_rt_data, wb_ra_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  postinc_lsu #(.XLEN(XL)) uut (.*);

  typedef struct { logic [XL-1:0] addr; logic we; logic [1:0] sz; logic [XL-1:0] wdata;
                   logic [XL-1:0] rdata; int stall; string tag; } req_t;
  typedef struct { logic ill; logic rt_en; logic [4:0] rt_idx; logic [XL-1:0] rt;
                   logic [4:0] ra_idx; logic [XL-1:0] ra; string tag; } wb_t;

  req_t req_q[$];
  wb_t  wb_q[$];
  int   n_chk = 0, n_err = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] sx16(input logic [15:0] v);
    return {{(XL-16){v[15]}}, v};
  endfunction

  task automatic run_op(input logic [1:0] sz, input bit st, input bit sg, input bit ix,
                        input bit po, input logic [4:0] bi, input logic [4:0] ti,
                        input logic [XL-1:0] base, input logic [XL-1:0] idx,
                        input logic [15:0] disp, input logic [XL-1:0] sdata,
                        input logic [XL-1:0] rdata, input int stall, input string tag);
    logic [XL-1:0] off, sum, ld, wd;
    req_t r; wb_t w;
    off = ix ? idx : ((sz == 2'd3) ? sx16({disp[13:0], 2'b00}) : sx16(disp));
    sum = base + off;
    case (sz)
      2'd0: begin ld = {56'd0, rdata[7:0]}; wd = {56'd0, sdata[7:0]}; end
      2'd1: begin ld = sg ? {{48{rdata[15]}}, rdata[15:0]} : {48'd0, rdata[15:0]};
                  wd = {48'd0, sdata[15:0]}; end
      2'd2: begin ld = sg ? {{32{rdata[31]}}, rdata[31:0]} : {32'd0, rdata[31:0]};
                  wd = {32'd0, sdata[31:0]}; end
      default: begin ld = rdata; wd = sdata; end
    endcase
    w.tag = tag;
    if (bi == 5'd0 || (!st && bi == ti)) begin
      w.ill = 1'b1; w.rt_en = 1'b0; w.rt_idx = '0; w.rt = '0; w.ra_idx = '0; w.ra = '0;
    end else begin
      r.addr = po ? base : sum; r.we = st; r.sz = sz; r.wdata = wd; r.rdata = rdata;
      r.stall = stall; r.tag = tag;
      req_q.push_back(r);
      w.ill = 1'b0; w.rt_en = !st; w.rt_idx = ti; w.rt = ld; w.ra_idx = bi; w.ra = sum;
    end
    wb_q.push_back(w);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_size = sz; op_store = st; op_signed = sg; op_indexed = ix;
    op_post = po; op_base_idx = bi; op_tgt_idx = ti; op_base = base; op_index = idx;
    op_disp = disp; op_sdata = sdata;
    @(negedge clk);
    op_valid = 1'b0;
    while (wb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // memory model: checks each request against the scoreboard, then answers
  initial begin
    forever begin
      @(negedge clk);
      if (mreq_valid) begin
        req_t r;
        if (req_q.size() == 0) begin
          check(1'b0, "R9", "unexpected request addr", mreq_addr, '0);
        end else begin
          r = req_q.pop_front();
          check(mreq_addr == r.addr, r.tag, "request address", mreq_addr, r.addr);
          check(mreq_we == r.we, r.tag, "request write flag", XL'(mreq_we), XL'(r.we));
          check(mreq_size == r.sz, r.tag, "request size", XL'(mreq_size), XL'(r.sz));
          if (r.we) check(mreq_wdata == r.wdata, r.tag, "R8 write data", mreq_wdata, r.wdata);
          check(!op_ready, "R10", "op_ready while busy", XL'(op_ready), '0);
          repeat (r.stall) @(negedge clk);
          check(mreq_valid && mreq_addr == r.addr, "R10", "request held", mreq_addr, r.addr);
          mreq_ready = 1'b1;
          @(negedge clk);
          mreq_ready = 1'b0;
          mresp_valid = 1'b1; mresp_data = r.rdata;
          @(negedge clk);
          mresp_valid = 1'b0; mresp_data = '0;
        end
      end
    end
  end

  // writeback monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (wb_ra_en || wb_rt_en || illegal)) begin
        wb_t w;
        if (wb_q.size() == 0) begin
          check(1'b0, "R11", "unexpected writeback", wb_ra_data, '0);
        end else begin
          w = wb_q.pop_front();
          check(illegal == w.ill, w.tag, "illegal flag R9", XL'(illegal), XL'(w.ill));
          check(wb_rt_en == w.rt_en, w.tag, "target enable R11", XL'(wb_rt_en), XL'(w.rt_en));
          check(wb_ra_en == !w.ill, w.tag, "base enable R11", XL'(wb_ra_en), XL'(!w.ill));
          check(op_ready, "R11", "ready at writeback", XL'(op_ready), 64'd1);
          if (!w.ill) begin
            check(wb_ra_data == w.ra, w.tag, "base value", wb_ra_data, w.ra);
            check(wb_ra_idx == w.ra_idx, w.tag, "base index", XL'(wb_ra_idx), XL'(w.ra_idx));
          end
          if (w.rt_en) begin
            check(wb_rt_data == w.rt, w.tag, "load result", wb_rt_data, w.rt);
            check(wb_rt_idx == w.rt_idx, w.tag, "target index", XL'(wb_rt_idx), XL'(w.rt_idx));
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R10 watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  localparam logic [XL-1:0] MEMV = 64'hFFEE_DDCC_1234_8123;
  localparam logic [XL-1:0] SDV  = 64'h1122_3344_5566_7788;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(op_ready == 1'b1, "R12", "op_ready", XL'(op_ready), 64'd1);
    check(mreq_valid == 1'b0, "R12", "mreq_valid", XL'(mreq_valid), '0);
    check(!wb_rt_en && !wb_ra_en, "R12", "write enables", XL'({wb_rt_en, wb_ra_en}), '0);
    check(illegal == 1'b0, "R12", "illegal", XL'(illegal), '0);

    // R1 R2 R6: post, immediate, zero byte load
    run_op(2'd0, 0, 0, 0, 1, 5'd3, 5'd4, 64'h1000, '0, 16'h0010, '0, 64'h0102_0304_0506_0780, 0, "R1_R2_R6");
    // R3 R7: pre, negative displacement, signed halfword
    run_op(2'd1, 0, 1, 0, 0, 5'd5, 5'd6, 64'h2000, '0, 16'hFFF8, '0, MEMV, 1, "R3_R7");
    // R4 R7: post, indexed, signed word
    run_op(2'd2, 0, 1, 1, 1, 5'd7, 5'd8, 64'h3000, 64'hFFFF_FFFF_FFFF_FF00, 16'h7777, '0, 64'h1234_5678_8000_0001, 2, "R4_R7");
    // R6: zero word load, pre, indexed
    run_op(2'd2, 0, 0, 1, 0, 5'd9, 5'd10, 64'h4000, 64'h100, '0, '0, 64'h1234_5678_8000_0001, 0, "R4_R6");
    // R7: signed flag ignored for byte
    run_op(2'd0, 0, 1, 0, 1, 5'd11, 5'd12, 64'h5000, '0, 16'h0001, '0, 64'hF0, 0, "R7");
    // R5: doubleword immediate, field -1 -> offset -4, post
    run_op(2'd3, 0, 0, 0, 1, 5'd13, 5'd14, 64'h6000, '0, 16'h3FFF, '0, MEMV, 0, "R5");
    // R5: upper displacement bits ignored, pre
    run_op(2'd3, 0, 1, 0, 0, 5'd15, 5'd16, 64'h7000, '0, 16'hC001, '0, MEMV, 0, "R5");
    // R8 R10: stores of every size with stalls
    run_op(2'd0, 1, 0, 0, 1, 5'd17, 5'd17, 64'h8000, '0, 16'h0001, SDV, '0, 3, "R8_R10");
    run_op(2'd1, 1, 0, 1, 0, 5'd18, 5'd2, 64'h8100, 64'h2, '0, SDV, '0, 0, "R8");
    run_op(2'd2, 1, 0, 0, 0, 5'd19, 5'd2, 64'h8200, '0, 16'h0004, SDV, '0, 1, "R8");
    run_op(2'd3, 1, 0, 0, 1, 5'd20, 5'd2, 64'h8300, '0, 16'h0002, SDV, '0, 0, "R8");
    // R9: base register 0, and load with base == target
    run_op(2'd2, 0, 0, 0, 1, 5'd0, 5'd4, 64'h9000, '0, 16'h0004, '0, '0, 0, "R9");
    run_op(2'd1, 0, 0, 1, 0, 5'd21, 5'd21, 64'h9100, 64'h8, '0, '0, '0, 0, "R9");
    run_op(2'd0, 1, 0, 0, 0, 5'd0, 5'd1, 64'h9200, '0, 16'h0001, SDV, '0, 0, "R9");
    check(op_ready, "R9", "ready after refusals", XL'(op_ready), 64'd1);
    // back to back after refusal still works
    run_op(2'd3, 0, 0, 1, 1, 5'd22, 5'd23, 64'hA000, 64'h40, '0, '0, MEMV, 2, "R2_R11");

    check(req_q.size() == 0, "R10", "leftover requests", XL'(req_q.size()), '0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule